// File: doc/BRIEF.md
# Subframe ID Major-Frame Tracker

This block sits behind a minor-frame synchronizer that has already found word boundaries. Each minor frame carries a subframe identifier: a counter held in one fixed word slot that steps by one from frame to frame. The identifier returns to a chosen starting count at the first minor frame of each major frame. The tracker takes that counter from the word stream and checks that it really steps in sequence. From it the block reports which minor frame of the major frame is current. A decommutator downstream uses these outputs to place subcommutated words.

Configuration sets the word slot that carries the identifier and the bit field inside that word. It also sets the starting count and the major-frame length. The length is written as length minus one, so the default 16-bit counter covers up to 65,536 minor frames. The tracker declares major-frame lock after a short run of in-sequence identifiers. While locked it rides through a single bad identifier on its own prediction. It gives lock up after repeated misses. When the upstream minor-frame lock goes away, the tracker starts over.

Top module: `sfid_tracker`

## Requirements
- R1: After reset, `major_lock`, `major_start` and `cnt_err` are low and `minor_num` is 0.
- R2: The identifier is `(word_data >> cfg_field_lsb) & cfg_field_mask`. It is taken only from a valid word whose `word_idx` equals `cfg_sfid_pos`, and only from the first such word after a `frame_start`. Any further word with that index before the next `frame_start` is ignored.
- R3: The expected next identifier is the previous one plus one. After the last count, `cfg_init + cfg_len_m1`, the expected value wraps back to `cfg_init`.
- R4: Starting from a reference identifier, `major_lock` rises on the second consecutive identifier that matches the expected value. The first identifier after an acquisition start serves only as the reference and raises no error.
- R5: Every identifier that differs from the expected value, once a reference exists, raises `cnt_err` for exactly one cycle. No other event raises it.
- R6: While locked, a single out-of-sequence identifier keeps `major_lock` high. The tracked position advances to the predicted value instead of the received one.
- R7: While locked, a second consecutive out-of-sequence identifier clears `major_lock`. That identifier becomes the new reference for re-acquisition.
- R8: `major_start` pulses for one cycle when an identifier is processed with the tracker locked and the tracked count equal to `cfg_init`. At that point `minor_num` is 0.
- R9: `minor_num` is the tracked identifier minus `cfg_init`, modulo 2^CNT_W.
- R10: When `mf_locked` is low, the tracker clears `major_lock`, drops its reference and sets `minor_num` to 0 on the next clock edge. Identifier words that arrive in that state are ignored.
- R11: All outputs change one clock edge after the identifier word is presented. At no other time do they change, apart from the R10 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_locked | input | 1 | Upstream minor-frame synchronizer holds lock |
| frame_start | input | 1 | Strobe marking the first word of a minor frame |
| word_valid | input | 1 | A data word is present this cycle |
| word_idx | input | IDX_W | Index of the word within its minor frame |
| word_data | input | WORD_W | Word contents |
| cfg_sfid_pos | input | IDX_W | Word index that carries the identifier |
| cfg_field_lsb | input | LSB_W | Lowest bit of the identifier field |
| cfg_field_mask | input | CNT_W | Mask applied to the shifted word |
| cfg_init | input | CNT_W | Count that marks the first minor frame of a major frame |
| cfg_len_m1 | input | CNT_W | Major-frame length minus one |
| minor_num | output | CNT_W | Minor-frame number within the major frame |
| major_start | output | 1 | One-cycle pulse at the start of a major frame |
| major_lock | output | 1 | Major-frame lock |
| cnt_err | output | 1 | One-cycle pulse for an out-of-sequence identifier |

## Verification
Each result is due exactly one clock edge after the identifier word is presented. After `mf_locked` falls, the clear is also due one edge later. The driver drives inputs on the falling edge. In the same cycle that it presents an identifier word, it pushes the expected lock, pulses and position into a queue and raises a due flag. That flag is registered on the rising edge, so the monitor pops and compares the item on the following falling edge, after the single register stage has updated. In every other cycle the monitor requires both pulses to be low. An ignored duplicate word or a late result would therefore show up as a spurious pulse, or as a mismatch on the next expected item.

// File: rtl/sfid_pkg.sv
package sfid_pkg;

  // Tracker acquisition state
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,  // no reference identifier held
    TRK_ACQ  = 2'd1,  // reference held, counting in-sequence hits
    TRK_LOCK = 2'd2   // major-frame lock
  } trk_state_e;

endpackage

// File: rtl/sfid_extract.sv
module sfid_extract #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 10,
  parameter int CNT_W  = 16,
  parameter int LSB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_lock,
  input  logic              frame_start,
  input  logic              word_valid,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  input  logic [IDX_W-1:0]  cfg_pos,
  input  logic [LSB_W-1:0]  cfg_lsb,
  input  logic [CNT_W-1:0]  cfg_mask,
  output logic              cap_vld,
  output logic [CNT_W-1:0]  cap_val
);

  logic              seen_q;
  logic              seen_d;
  logic [WORD_W-1:0] shifted;
  logic [CNT_W-1:0]  widened;

  assign shifted = word_data >> cfg_lsb;

  // Fit the shifted word to the counter width
  generate
    if (CNT_W > WORD_W) begin : g_pad
      assign widened = {{(CNT_W-WORD_W){1'b0}}, shifted};
    end else if (CNT_W == WORD_W) begin : g_same
      assign widened = shifted;
    end else begin : g_trim
      assign widened = shifted[CNT_W-1:0];
    end
  endgenerate

  // First matching word of a frame only; frame_start reopens the window
  assign cap_vld = up_lock && word_valid && (word_idx == cfg_pos)
                   && (!seen_q || frame_start);
  assign cap_val = widened & cfg_mask;

  always_comb begin
    seen_d = seen_q;
    if (!up_lock) begin
      seen_d = 1'b0;
    end else if (cap_vld) begin
      seen_d = 1'b1;
    end else if (frame_start) begin
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

endmodule

// File: rtl/sfid_next_calc.sv
module sfid_next_calc #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cur_val,
  input  logic [CNT_W-1:0] cfg_init,
  input  logic [CNT_W-1:0] cfg_len_m1,
  output logic [CNT_W-1:0] nxt_val
);

  logic [CNT_W-1:0] last_val;
  logic             at_last;

  assign last_val = cfg_init + cfg_len_m1;
  assign at_last  = (cur_val == last_val);
  assign nxt_val  = at_last ? cfg_init : (cur_val + CNT_W'(1));

endmodule

// File: rtl/sfid_lock_fsm.sv
module sfid_lock_fsm
  import sfid_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOCK_HITS   = 2,
  parameter int DROP_MISSES = 2,
  localparam int HIT_W  = $clog2(LOCK_HITS + 1),
  localparam int MISS_W = $clog2(DROP_MISSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_lock,
  input  logic             cap_vld,
  input  logic [CNT_W-1:0] cap_val,
  input  logic [CNT_W-1:0] nxt_val,
  input  logic [CNT_W-1:0] cfg_init,
  output logic [CNT_W-1:0] cur_val,
  output logic [CNT_W-1:0] pos_val,
  output logic             lock_out,
  output logic             start_out,
  output logic             err_out
);

  trk_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cur_q, cur_d;
  logic [CNT_W-1:0]  pos_q, pos_d;
  logic [HIT_W-1:0]  hit_q, hit_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              start_q, start_d;
  logic              err_q, err_d;
  logic              seq_ok;
  logic              upd_en;

  assign seq_ok = (cap_val == nxt_val);
  assign upd_en = !up_lock || cap_vld;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    pos_d   = pos_q;
    hit_d   = hit_q;
    miss_d  = miss_q;
    start_d = 1'b0;
    err_d   = 1'b0;
    if (!up_lock) begin
      st_d   = TRK_IDLE;
      hit_d  = '0;
      miss_d = '0;
      pos_d  = '0;
    end else if (cap_vld) begin
      unique case (st_q)
        TRK_IDLE: begin
          st_d   = TRK_ACQ;
          cur_d  = cap_val;
          hit_d  = '0;
          miss_d = '0;
        end
        TRK_ACQ: begin
          cur_d = cap_val;
          if (seq_ok) begin
            if (hit_q == HIT_W'(LOCK_HITS - 1)) begin
              st_d    = TRK_LOCK;
              hit_d   = '0;
              start_d = (cap_val == cfg_init);
            end else begin
              hit_d = hit_q + HIT_W'(1);
            end
          end else begin
            hit_d = '0;
            err_d = 1'b1;
          end
        end
        TRK_LOCK: begin
          if (seq_ok) begin
            cur_d   = cap_val;
            miss_d  = '0;
            start_d = (cap_val == cfg_init);
          end else begin
            err_d = 1'b1;
            if (miss_q == MISS_W'(DROP_MISSES - 1)) begin
              st_d   = TRK_ACQ;
              miss_d = '0;
              hit_d  = '0;
              cur_d  = cap_val;
            end else begin
              miss_d  = miss_q + MISS_W'(1);
              cur_d   = nxt_val;
              start_d = (nxt_val == cfg_init);
            end
          end
        end
        default: begin
          st_d = TRK_IDLE;
        end
      endcase
      pos_d = cur_d - cfg_init;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_IDLE;
      cur_q  <= '0;
      pos_q  <= '0;
      hit_q  <= '0;
      miss_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      pos_q  <= pos_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      err_q   <= err_d;
    end
  end

  assign cur_val   = cur_q;
  assign pos_val   = pos_q;
  assign lock_out  = (st_q == TRK_LOCK);
  assign start_out = start_q;
  assign err_out   = err_q;

endmodule

// File: rtl/sfid_tracker.sv
module sfid_tracker #(
  parameter int WORD_W      = 16,
  parameter int IDX_W       = 10,
  parameter int CNT_W       = 16,
  parameter int LOCK_HITS   = 2,
  parameter int DROP_MISSES = 2,
  localparam int LSB_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mf_locked,
  input  logic              frame_start,
  input  logic              word_valid,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  input  logic [IDX_W-1:0]  cfg_sfid_pos,
  input  logic [LSB_W-1:0]  cfg_field_lsb,
  input  logic [CNT_W-1:0]  cfg_field_mask,
  input  logic [CNT_W-1:0]  cfg_init,
  input  logic [CNT_W-1:0]  cfg_len_m1,
  output logic [CNT_W-1:0]  minor_num,
  output logic              major_start,
  output logic              major_lock,
  output logic              cnt_err
);

  logic             cap_vld;
  logic [CNT_W-1:0] cap_val;
  logic [CNT_W-1:0] cur_val;
  logic [CNT_W-1:0] nxt_val;

  sfid_extract #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .LSB_W  (LSB_W)
  ) u_extract (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_lock     (mf_locked),
    .frame_start (frame_start),
    .word_valid  (word_valid),
    .word_idx    (word_idx),
    .word_data   (word_data),
    .cfg_pos     (cfg_sfid_pos),
    .cfg_lsb     (cfg_field_lsb),
    .cfg_mask    (cfg_field_mask),
    .cap_vld     (cap_vld),
    .cap_val     (cap_val)
  );

  sfid_next_calc #(
    .CNT_W (CNT_W)
  ) u_next (
    .cur_val    (cur_val),
    .cfg_init   (cfg_init),
    .cfg_len_m1 (cfg_len_m1),
    .nxt_val    (nxt_val)
  );

  sfid_lock_fsm #(
    .CNT_W       (CNT_W),
    .LOCK_HITS   (LOCK_HITS),
    .DROP_MISSES (DROP_MISSES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_lock   (mf_locked),
    .cap_vld   (cap_vld),
    .cap_val   (cap_val),
    .nxt_val   (nxt_val),
    .cfg_init  (cfg_init),
    .cur_val   (cur_val),
    .pos_val   (minor_num),
    .lock_out  (major_lock),
    .start_out (major_start),
    .err_out   (cnt_err)
  );

endmodule

// File: rtl/sfid_tracker_chk.sv
module sfid_tracker_chk #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mf_locked,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_idx,
  input logic [IDX_W-1:0] cfg_sfid_pos,
  input logic [CNT_W-1:0] minor_num,
  input logic             major_start,
  input logic             major_lock,
  input logic             cnt_err
);

  logic slot_seen;
  assign slot_seen = mf_locked && word_valid && (word_idx == cfg_sfid_pos);

  assert_start_at_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    major_start |-> (major_lock && (minor_num == '0)));

  assert_err_needs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> $past(slot_seen));

  assert_upstream_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mf_locked) |-> (!major_lock && (minor_num == '0)));

  assert_lock_on_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(major_lock) |-> (!cnt_err && $past(slot_seen)));

  assert_drop_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(major_lock) && $past(mf_locked)) |-> cnt_err);

  assert_pos_moves_on_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(minor_num) |-> ($past(slot_seen) || !$past(mf_locked)));

endmodule

bind sfid_tracker sfid_tracker_chk #(
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mf_locked    (mf_locked),
  .word_valid   (word_valid),
  .word_idx     (word_idx),
  .cfg_sfid_pos (cfg_sfid_pos),
  .minor_num    (minor_num),
  .major_start  (major_start),
  .major_lock   (major_lock),
  .cnt_err      (cnt_err)
);

// File: tb/sfid_tracker_tb.sv
module sfid_tracker_tb;

  localparam int WORD_W = 16;
  localparam int IDX_W  = 10;
  localparam int CNT_W  = 16;
  localparam int LSB_W  = $clog2(WORD_W);
  localparam int FRAME_WORDS = 6;
  localparam logic [IDX_W-1:0] POS    = 10'd2;
  localparam logic [CNT_W-1:0] INIT   = 16'h0010;
  localparam logic [CNT_W-1:0] LEN_M1 = 16'h0003;

  typedef struct packed {
    logic             lock;
    logic             ms;
    logic             err;
    logic             chk_minor;
    logic [CNT_W-1:0] minor;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              mf_locked;
  logic              frame_start;
  logic              word_valid;
  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] word_data;
  logic [CNT_W-1:0]  minor_num;
  logic              major_start;
  logic              major_lock;
  logic              cnt_err;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic tb_push = 1'b0;
  logic due_q   = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  // Reference model state
  int               m_st = 0;   // 0 none, 1 acquiring, 2 locked
  logic [CNT_W-1:0] m_cur = '0;
  int               m_hit = 0;
  int               m_miss = 0;

  sfid_tracker #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .mf_locked      (mf_locked),
    .frame_start    (frame_start),
    .word_valid     (word_valid),
    .word_idx       (word_idx),
    .word_data      (word_data),
    .cfg_sfid_pos   (POS),
    .cfg_field_lsb  (LSB_W'(4)),
    .cfg_field_mask (16'h00FF),
    .cfg_init       (INIT),
    .cfg_len_m1     (LEN_M1),
    .minor_num      (minor_num),
    .major_start    (major_start),
    .major_lock     (major_lock),
    .cnt_err        (cnt_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [WORD_W-1:0] pack_word(input logic [7:0] s);
    return {4'hA, s, 4'h5};
  endfunction

  task automatic model_step(input logic [CNT_W-1:0] s, output exp_t e);
    logic [CNT_W-1:0] nxt;
    nxt = (m_cur == INIT + LEN_M1) ? INIT : m_cur + 16'd1;
    e = '0;
    e.chk_minor = 1'b1;
    if (m_st == 0) begin
      m_st = 1; m_cur = s; m_hit = 0; m_miss = 0;
    end else if (m_st == 1) begin
      m_cur = s;
      if (s == nxt) begin
        m_hit++;
        if (m_hit == 2) begin m_st = 2; m_hit = 0; e.ms = (s == INIT); end
      end else begin
        m_hit = 0; e.err = 1'b1;
      end
    end else begin
      if (s == nxt) begin
        m_cur = s; m_miss = 0; e.ms = (s == INIT);
      end else begin
        e.err = 1'b1;
        m_miss++;
        if (m_miss == 2) begin m_st = 1; m_miss = 0; m_hit = 0; m_cur = s; end
        else begin m_cur = nxt; e.ms = (nxt == INIT); end
      end
    end
    e.lock  = (m_st == 2);
    e.minor = m_cur - INIT;
  endtask

  task automatic send_frame(input logic [7:0] s, input bit dup, input string tag);
    exp_t e;
    for (int i = 0; i < FRAME_WORDS; i++) begin
      @(negedge clk);
      frame_start = (i == 0);
      word_valid  = 1'b1;
      word_idx    = IDX_W'(i);
      tb_push     = 1'b0;
      if (IDX_W'(i) == POS) begin
        word_data = pack_word(s);
        model_step({8'h00, s}, e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tb_push = 1'b1;
      end else begin
        word_data = 16'h3C00 + WORD_W'(i);
      end
    end
    if (dup) begin
      // R2: repeated identifier slot inside the same frame, must be ignored
      @(negedge clk);
      frame_start = 1'b0;
      tb_push     = 1'b0;
      word_idx    = POS;
      word_data   = pack_word(8'h77);
    end
    @(negedge clk);
    frame_start = 1'b0;
    word_valid  = 1'b0;
    tb_push     = 1'b0;
  endtask

  task automatic drop_upstream(input string tag);
    exp_t e;
    @(negedge clk);
    mf_locked = 1'b0;
    m_st = 0; m_hit = 0; m_miss = 0;
    e = '0;
    e.chk_minor = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    tb_push = 1'b1;
    // R10: identifier word while upstream lock is absent, must be ignored
    word_valid = 1'b1;
    word_idx   = POS;
    word_data  = pack_word(8'h12);
    @(negedge clk);
    tb_push    = 1'b0;
    word_valid = 1'b0;
    repeat (3) @(negedge clk);
    mf_locked = 1'b1;
  endtask

  always @(posedge clk) due_q <= tb_push;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (due_q === 1'b1) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R11: result due but no expected item (actual lock=%0b)", major_lock);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (major_lock !== e.lock || major_start !== e.ms || cnt_err !== e.err ||
              (e.chk_minor && minor_num !== e.minor)) begin
            fails++;
            $display("FAIL %s: actual lock=%0b start=%0b err=%0b minor=%0h expected lock=%0b start=%0b err=%0b minor=%0h",
                     t, major_lock, major_start, cnt_err, minor_num,
                     e.lock, e.ms, e.err, e.minor);
          end
        end
      end else begin
        checks++;
        if (major_start !== 1'b0 || cnt_err !== 1'b0) begin
          fails++;
          $display("FAIL R5/R8/R11: pulse outside a result cycle, actual start=%0b err=%0b expected 0 0",
                   major_start, cnt_err);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    mf_locked   = 1'b0;
    frame_start = 1'b0;
    word_valid  = 1'b0;
    word_idx    = '0;
    word_data   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (major_lock !== 1'b0 || major_start !== 1'b0 || cnt_err !== 1'b0 || minor_num !== '0) begin
      fails++;
      $display("FAIL R1: actual lock=%0b start=%0b err=%0b minor=%0h expected 0 0 0 0",
               major_lock, major_start, cnt_err, minor_num);
    end
    mf_locked = 1'b1;
    @(negedge clk);

    send_frame(8'h11, 0, "R4 reference");
    send_frame(8'h12, 0, "R4 first hit");
    send_frame(8'h13, 0, "R4 lock R9 position");
    send_frame(8'h10, 0, "R3 wrap R8 start");
    send_frame(8'h11, 0, "R9 in lock");
    send_frame(8'h12, 1, "R2 before duplicate");
    send_frame(8'h13, 0, "R2 duplicate ignored");
    send_frame(8'h55, 0, "R6 single miss flywheel");
    send_frame(8'h11, 0, "R6 recovered");
    send_frame(8'h40, 0, "R6 first miss");
    send_frame(8'h41, 0, "R7 second miss drops");
    send_frame(8'h12, 0, "R7 reacquire mismatch R5");
    send_frame(8'h13, 0, "R7 reacquire hit");
    send_frame(8'h10, 0, "R3 wrap during acquire R4");
    drop_upstream("R10 upstream loss");
    send_frame(8'h11, 0, "R10 fresh reference");
    send_frame(8'h12, 0, "R10 hit");
    send_frame(8'h13, 0, "R10 relock");
    repeat (4) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d results never checked, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule